// File: doc/BRIEF.md
# HDB3 Line Decoder with Violation Monitor

This block sits behind a line interface that delivers a bipolar E3 signal as two unipolar rails, one carrying positive pulses and one carrying negative pulses, together with a recovered line clock. It turns the rail pulses back into a binary bit stream. It recognises the two zero-substitution codes of HDB3 and writes four zeros in their place. It also checks the line for coding errors and counts them.

Each received pulse is classed as one of two kinds. An ordinary mark alternates in polarity with the previous mark. A violation repeats the previous polarity. A violation is taken as a substitution code only when two conditions hold: an odd number of ordinary marks lies between it and the last accepted violation, and it follows at least two zero symbols. Any other violation is a line code violation (LCV). Two other conditions also raise an LCV: pulses on both rails in the same bit period, and zero runs that are longer than HDB3 allows. Every LCV produces a one-cycle pulse. It also advances a free-running event counter and a per-second accumulator. A one-second tick moves the accumulator into a holding register.

The decoded stream leaves on `dout` qualified by `dout_valid`. There is no ready signal. The line clock cannot be stalled, so the stream accepts no back-pressure. A consumer must take one bit on every line clock in which `dout_valid` is high. Once `dout_valid` has risen after reset, it stays high.

Top module: `hdb3_line_decoder`

## Requirements
- R1: In AMI operation, a single-rail pulse decodes as 1 and a symbol with neither rail high decodes as 0. Each bit appears on `dout` exactly 4 rising edges after the edge that moves its symbol into the decoder. `dout_valid` goes high with the first symbol captured after reset and stays high.
- R2: A zero, zero, zero, violation sequence that is accepted as a substitution is output as four zeros.
- R3: A mark, zero, zero, violation sequence that is accepted as a substitution is output as four zeros, so the leading mark is cancelled.
- R4: A violation is a single-rail pulse (positive rail = polarity 1) with the same polarity as the previous single-rail pulse. It is accepted only when the number of ordinary marks since the last accepted violation is odd and the two symbols before it are zeros. Otherwise it raises an LCV and decodes as 1. After reset the previous polarity is negative and the mark count is odd.
- R5: Both rails high in one bit period raises an LCV and decodes as 1. It leaves the polarity and mark-count tracking unchanged.
- R6: The fourth consecutive zero symbol raises one LCV per run. A run of exactly three zeros ended by anything other than an accepted violation also raises one LCV. When several causes coincide in one symbol, they count as a single event.
- R7: Each LCV gives a one-cycle `lcv_pulse` and adds one to `lcv_events`, one rising edge after the edge that captured the symbol.
- R8: Each LCV also adds one to `lcv_sec_acc`. On an edge that samples `sec_tick` high, `lcv_sec_hold` takes the accumulator value including any event on that same edge, and the accumulator restarts at zero.
- R9: `lcv_events` and `lcv_sec_acc` saturate at all ones.
- R10: `cnt_clr`, sampled on a rising edge, zeroes the event counter, the accumulator and the holding register. It takes priority over events and `sec_tick`.
- R11: With `fall_edge_sel` = 1 the rails are sampled on the falling edge of the line clock; with 0, on the rising edge. In both cases the sample enters the decoder on the next rising edge.
- R12: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_line | input | 1 | Recovered line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fall_edge_sel | input | 1 | 1: sample rails on falling edge; 0: rising edge |
| rail_pos | input | 1 | Positive pulse rail |
| rail_neg | input | 1 | Negative pulse rail |
| sec_tick | input | 1 | One-second strobe, one cycle |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| dout | output | 1 | Decoded binary data |
| dout_valid | output | 1 | Marks `dout` as carrying a decoded bit |
| lcv_pulse | output | 1 | One-cycle line code violation flag |
| lcv_events | output | CNT_W (16) | Saturating LCV event counter |
| lcv_sec_acc | output | CNT_W (16) | Running one-second LCV accumulator |
| lcv_sec_hold | output | CNT_W (16) | Accumulator value latched at the last tick |

## Verification
Symbols enter the decoder on the rising edge after they are driven. The decoded bit then appears on `dout` four edges later, so the reference keeps its expected bits in a queue and compares each output against the symbol driven five steps earlier. `lcv_pulse` and both counters reflect a symbol one edge after it enters the decoder, and `sec_tick` and `cnt_clr` act on the edge that samples them. The reference replays these delays exactly. Outputs are compared one time unit after every rising edge, never at the edge itself. In falling-edge mode the rails are scrambled after each falling edge, so sampling on the wrong edge shows up as a miscompare.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  // One received bit period on the two rails.
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_sym_t;

  // Length of a zero-substitution code in bit periods.
  localparam int SUB_LEN = 4;

endpackage

// File: rtl/hdb3_rail_sampler.sv
module hdb3_rail_sampler
  import hdb3_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fall_sel,
  input  logic      rail_p,
  input  logic      rail_n,
  output rail_sym_t sym,
  output logic      sym_vld
);

  rail_sym_t fall_q;

  // Falling-edge capture, retimed on the following rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
    end else begin
      fall_q.pos <= rail_p;
      fall_q.neg <= rail_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym     <= '0;
      sym_vld <= 1'b0;
    end else begin
      if (fall_sel) begin
        sym <= fall_q;
      end else begin
        sym.pos <= rail_p;
        sym.neg <= rail_n;
      end
      sym_vld <= 1'b1;
    end
  end

  p_vld_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |=> sym_vld);

endmodule

// File: rtl/hdb3_sym_decoder.sv
module hdb3_sym_decoder
  import hdb3_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rail_sym_t sym,
  input  logic      sym_vld,
  output logic      dec_bit,
  output logic      dec_vld,
  output logic      sub_hit,
  output logic      lcv_ev
);

  localparam int RUN_W = $clog2(SUB_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_CAP  = RUN_W'(SUB_LEN);
  localparam logic [RUN_W-1:0] RUN_WARN = RUN_W'(SUB_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_PRE  = RUN_W'(SUB_LEN - 2);

  logic             last_pos;  // polarity of the latest single-rail pulse
  logic             b_odd;     // ordinary marks since last accepted violation
  logic [RUN_W-1:0] zrun;      // zero symbols just before the current one

  logic is_zero, is_both, is_single, is_viol, v_ok, excess;

  always_comb begin
    is_zero   = !sym.pos && !sym.neg;
    is_both   = sym.pos && sym.neg;
    is_single = sym.pos ^ sym.neg;
    is_viol   = is_single && (sym.pos == last_pos);
    v_ok      = is_viol && b_odd && (zrun >= RUN_PRE);
    excess    = (zrun == RUN_WARN) && !v_ok;
    lcv_ev    = sym_vld && (is_both || (is_viol && !v_ok) || excess);
    sub_hit   = sym_vld && v_ok;
    dec_bit   = !is_zero && !v_ok;
    dec_vld   = sym_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos <= 1'b0;
      b_odd    <= 1'b1;
      zrun     <= '0;
    end else if (sym_vld) begin
      if (is_zero) begin
        zrun <= (zrun == RUN_CAP) ? RUN_CAP : zrun + 1'b1;
      end else begin
        zrun <= '0;
      end
      if (is_single) begin
        last_pos <= sym.pos;
        if (v_ok) begin
          b_odd <= 1'b0;
        end else if (!is_viol) begin
          b_odd <= !b_odd;
        end
      end
    end
  end

  p_both_keeps_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && is_both) |=> ($stable(last_pos) && $stable(b_odd)));

  p_accept_resets_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_hit |=> !b_odd);

  p_run_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= RUN_CAP);

endmodule

// File: rtl/hdb3_sub_pipe.sv
module hdb3_sub_pipe
  import hdb3_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic vld_in,
  input  logic sub_in,
  output logic dout,
  output logic dv
);

  function automatic logic [DEPTH-1:0] build_mask();
    logic [DEPTH-1:0] m;
    for (int i = 0; i < DEPTH; i++) begin
      m[i] = (i < SUB_LEN);
    end
    return m;
  endfunction

  localparam logic [DEPTH-1:0] SUB_MASK = build_mask();

  logic [DEPTH-1:0] bits, vq, bits_nx;

  always_comb begin
    bits_nx = {bits[DEPTH-2:0], bit_in};
    if (sub_in) begin
      bits_nx = bits_nx & ~SUB_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
      vq   <= '0;
    end else begin
      bits <= bits_nx;
      vq   <= {vq[DEPTH-2:0], vld_in};
    end
  end

  assign dout = bits[DEPTH-1];
  assign dv   = vq[DEPTH-1];

  p_sub_window_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sub_in |=> ((bits & SUB_MASK) == '0));

  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dv |=> dv);

endmodule

// File: rtl/hdb3_lcv_counters.sv
module hdb3_lcv_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             clr,
  input  logic             tick,
  output logic             pulse,
  output logic [CNT_W-1:0] ev_cnt,
  output logic [CNT_W-1:0] acc,
  output logic [CNT_W-1:0] hold
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v, input logic inc);
    return (inc && v != CNT_MAX) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      ev_cnt <= '0;
      acc    <= '0;
      hold   <= '0;
    end else begin
      pulse <= ev;
      if (clr) begin
        ev_cnt <= '0;
        acc    <= '0;
        hold   <= '0;
      end else begin
        ev_cnt <= sat_add(ev_cnt, ev);
        if (tick) begin
          hold <= sat_add(acc, ev);
          acc  <= '0;
        end else begin
          acc <= sat_add(acc, ev);
        end
      end
    end
  end

  p_event_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ev && ev_cnt != CNT_MAX) |=> ev_cnt == CNT_W'($past(ev_cnt) + 1'b1));

  p_event_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ev_cnt == CNT_MAX) |=> ev_cnt == CNT_MAX);

  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ev_cnt == '0 && acc == '0 && hold == '0));

  p_tick_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick) |=> acc == '0);

endmodule

// File: rtl/hdb3_line_decoder.sv
module hdb3_line_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LAT_BITS = 4
) (
  input  logic             clk_line,
  input  logic             rst_n,
  input  logic             fall_edge_sel,
  input  logic             rail_pos,
  input  logic             rail_neg,
  input  logic             sec_tick,
  input  logic             cnt_clr,
  output logic             dout,
  output logic             dout_valid,
  output logic             lcv_pulse,
  output logic [CNT_W-1:0] lcv_events,
  output logic [CNT_W-1:0] lcv_sec_acc,
  output logic [CNT_W-1:0] lcv_sec_hold
);

  localparam int PIPE_D = (LAT_BITS < SUB_LEN) ? SUB_LEN : LAT_BITS;

  rail_sym_t sym;
  logic      sym_vld, dec_bit, dec_vld, sub_hit, lcv_ev;

  hdb3_rail_sampler u_sampler (
    .clk      (clk_line),
    .rst_n    (rst_n),
    .fall_sel (fall_edge_sel),
    .rail_p   (rail_pos),
    .rail_n   (rail_neg),
    .sym      (sym),
    .sym_vld  (sym_vld)
  );

  hdb3_sym_decoder u_decoder (
    .clk     (clk_line),
    .rst_n   (rst_n),
    .sym     (sym),
    .sym_vld (sym_vld),
    .dec_bit (dec_bit),
    .dec_vld (dec_vld),
    .sub_hit (sub_hit),
    .lcv_ev  (lcv_ev)
  );

  hdb3_sub_pipe #(.DEPTH(PIPE_D)) u_pipe (
    .clk    (clk_line),
    .rst_n  (rst_n),
    .bit_in (dec_bit),
    .vld_in (dec_vld),
    .sub_in (sub_hit),
    .dout   (dout),
    .dv     (dout_valid)
  );

  hdb3_lcv_counters #(.CNT_W(CNT_W)) u_counters (
    .clk    (clk_line),
    .rst_n  (rst_n),
    .ev     (lcv_ev),
    .clr    (cnt_clr),
    .tick   (sec_tick),
    .pulse  (lcv_pulse),
    .ev_cnt (lcv_events),
    .acc    (lcv_sec_acc),
    .hold   (lcv_sec_hold)
  );

endmodule

// File: tb/tb_hdb3_line_decoder.sv
module tb_hdb3_line_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int CW         = 16;
  localparam int MAXC       = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, fall_edge_sel = 1'b0, rail_pos = 1'b0, rail_neg = 1'b0;
  logic sec_tick = 1'b0, cnt_clr = 1'b0;
  logic dout, dout_valid, lcv_pulse;
  logic [CW-1:0] lcv_events, lcv_sec_acc, lcv_sec_hold;

  hdb3_line_decoder #(.CNT_W(CW), .LAT_BITS(4)) dut (
    .clk_line(clk), .rst_n(rst_n), .fall_edge_sel(fall_edge_sel),
    .rail_pos(rail_pos), .rail_neg(rail_neg), .sec_tick(sec_tick), .cnt_clr(cnt_clr),
    .dout(dout), .dout_valid(dout_valid), .lcv_pulse(lcv_pulse),
    .lcv_events(lcv_events), .lcv_sec_acc(lcv_sec_acc), .lcv_sec_hold(lcv_sec_hold)
  );

  always #(HALF) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int dec_q[$];
  int ev_q[$];
  int clr_q[$];
  int tick_q[$];
  int cur = 0;
  // reference state
  int m_last = 0, m_odd = 1, m_run = 0;
  int m_evc = 0, m_acc = 0, m_hold = 0;
  // stimulus encoder state
  int e_last = 0, e_odd = 1, e_pend = 0;
  bit nxt_clr = 1'b0, nxt_tick = 1'b0, fall_mode = 1'b0;
  int tick_every = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", tag, act, exp, cur);
    end
  endtask

  function automatic int sat(int v, int e);
    return (v + e > MAXC) ? MAXC : v + e;
  endfunction

  // Behavioural reference for one symbol, per R1-R6.
  function automatic void model_sym(int p, int n);
    int bv, ev, vok, isv, j;
    ev = 0; vok = 0; j = dec_q.size();
    if (p == 0 && n == 0) begin
      bv = 0;
      if (m_run == 3) ev = 1;
      if (m_run < 4) m_run++;
    end else if (p == 1 && n == 1) begin
      bv = 1; ev = 1; m_run = 0;
    end else begin
      isv = (p == m_last);
      vok = isv && (m_odd == 1) && (m_run >= 2);
      if (vok != 0) begin
        bv = 0;
        for (int k = 1; k <= 3; k++) if (j - k >= 0) dec_q[j-k] = 0;
        m_odd = 0;
      end else if (isv != 0) begin
        bv = 1; ev = 1;
      end else begin
        bv = 1; m_odd = 1 - m_odd;
      end
      if (m_run == 3 && vok == 0) ev = 1;
      m_last = p;
      m_run = 0;
    end
    dec_q.push_back(bv);
    ev_q.push_back(ev);
  endfunction

  task automatic step(int p, int n, string tag, string ctag);
    int e, c, s, tk;
    @(posedge clk); #1;
    e = 0;
    if (cur >= 1) begin
      c = clr_q[cur-1]; s = tick_q[cur-1];
      if (cur >= 2) e = ev_q[cur-2];
      if (c != 0) begin
        m_evc = 0; m_acc = 0; m_hold = 0;
      end else begin
        m_evc = sat(m_evc, e);
        if (s != 0) begin m_hold = sat(m_acc, e); m_acc = 0; end
        else m_acc = sat(m_acc, e);
      end
    end
    chk({tag, " valid"}, int'(dout_valid), (cur >= 5) ? 1 : 0);
    if (cur >= 5) chk({tag, " data"}, int'(dout), dec_q[cur-5]);
    chk({ctag, " pulse"}, int'(lcv_pulse), e);
    chk({ctag, " events"}, int'(lcv_events), m_evc);
    chk({ctag, " acc"}, int'(lcv_sec_acc), m_acc);
    chk({ctag, " hold"}, int'(lcv_sec_hold), m_hold);
    tk = (tick_every > 0 && (cur % tick_every) == 0) ? 1 : int'(nxt_tick);
    rst_n = 1'b1;
    fall_edge_sel = fall_mode;
    rail_pos = p[0]; rail_neg = n[0];
    sec_tick = tk[0]; cnt_clr = nxt_clr;
    clr_q.push_back(int'(nxt_clr));
    tick_q.push_back(tk);
    model_sym(p, n);
    cur++;
    if (fall_mode) begin
      #(HALF);
      rail_pos = !p[0]; rail_neg = !n[0];
    end
  endtask

  task automatic emit(int pol, string tag, string ctag);
    step(pol, 1 - pol, tag, ctag);
  endtask

  task automatic enc(int b, string tag, string ctag);
    if (b != 0) begin
      repeat (e_pend) step(0, 0, tag, ctag);
      e_pend = 0;
      e_last = 1 - e_last;
      emit(e_last, tag, ctag);
      e_odd = 1 - e_odd;
    end else begin
      e_pend++;
      if (e_pend == 4) begin
        if (e_odd != 0) begin
          repeat (3) step(0, 0, tag, ctag);
          emit(e_last, tag, ctag);
        end else begin
          e_last = 1 - e_last;
          emit(e_last, tag, ctag);
          repeat (2) step(0, 0, tag, ctag);
          emit(e_last, tag, ctag);
        end
        e_odd = 0;
        e_pend = 0;
      end
    end
  endtask

  task automatic enc_flush(string tag, string ctag);
    repeat (e_pend) step(0, 0, tag, ctag);
    e_pend = 0;
  endtask

  // code: 0 = no pulse, 1 = positive, 2 = negative, 3 = both rails
  task automatic raw(int code, string tag);
    step(code & 1, (code >> 1) & 1, tag, tag);
  endtask

  initial begin
    int seq4[23] = '{1,1,2,0,0,2,0,1,0,0,0,1,2,0,0,1,2,1,0,0,0,0,2};
    int seq5[10] = '{3,1,3,2,3,3,0,0,3,1};
    int seq6[16] = '{0,0,0,0,0,0,0,0,0,1,0,0,0,1,2,1};
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 dout", int'(dout), 0);
    chk("R12 valid", int'(dout_valid), 0);
    chk("R12 pulse", int'(lcv_pulse), 0);
    chk("R12 events", int'(lcv_events), 0);
    chk("R12 acc", int'(lcv_sec_acc), 0);
    chk("R12 hold", int'(lcv_sec_hold), 0);

    // R1: AMI/HDB3 legal stream, mostly ones
    for (int i = 0; i < 300; i++) enc(($urandom_range(0, 9) < 7) ? 1 : 0, "R1", "R7");
    enc_flush("R1", "R7");
    // R2: zero blocks after an odd mark count
    repeat (20) begin
      enc(1, "R2", "R7");
      repeat (4) enc(0, "R2", "R7");
    end
    // R3: zero blocks after an even mark count
    repeat (20) begin
      repeat (2) enc(1, "R3", "R7");
      repeat (4) enc(0, "R3", "R7");
    end
    // R1/R8: zero-rich legal stream with periodic ticks
    tick_every = 37;
    for (int i = 0; i < 300; i++) enc(($urandom_range(0, 1) == 1) ? 1 : 0, "R1", "R8");
    enc_flush("R1", "R8");
    tick_every = 0;
    // R4: invalid and valid violations
    foreach (seq4[i]) raw(seq4[i], "R4");
    // R5: both-rail symbols
    foreach (seq5[i]) raw(seq5[i], "R5");
    // R6: excessive zero runs
    foreach (seq6[i]) raw(seq6[i], "R6");
    // R11: falling-edge sampling with rails scrambled after each falling edge
    fall_mode = 1'b1;
    for (int i = 0; i < 200; i++) enc(($urandom_range(0, 2) != 0) ? 1 : 0, "R11", "R11");
    enc_flush("R11", "R11");
    fall_mode = 1'b0;
    repeat (3) raw(0, "R11");
    // R8: ticks during a dense violation stream
    tick_every = 7;
    repeat (40) raw(3, "R8");
    tick_every = 0;
    // R10: clear, also together with a tick
    repeat (5) raw(3, "R10");
    nxt_clr = 1'b1;
    raw(3, "R10");
    nxt_tick = 1'b1;
    raw(3, "R10");
    nxt_clr = 1'b0;
    raw(3, "R10");
    nxt_tick = 1'b0;
    repeat (5) raw(3, "R10");
    // R9: saturation of both counters
    repeat (MAXC + 10) raw(3, "R9");
    repeat (6) raw(0, "R9");
    nxt_tick = 1'b1;
    raw(0, "R9");
    nxt_tick = 1'b0;
    nxt_clr = 1'b1;
    raw(0, "R10");
    nxt_clr = 1'b0;
    repeat (8) raw(0, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion (step %0d)", cur);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule